// File: doc/BRIEF.md
# Branch Trace Capture Queue

This block keeps a short history of program-flow discontinuities for debug. The processor side presents one pre-classified event per cycle: either a taken branch instruction or an interrupt/exception entry. Each event yields a pair of addresses. The source is the branch instruction's own address for a branch, or the return address for an interrupt or exception. The destination is the target instruction, or the first instruction of the handler. The block stores the most recent pairs in a four-deep queue, oldest first.

Debug software reads the queue through two read strobes. The source strobe returns the oldest pair's source address. The destination strobe returns its destination address and then retires the pair. Capture runs only while the trace enable input is 1. Each off-to-on change of the enable discards what was held. A power-on reset clears the block completely. A manual reset or a debug-unit software reset also clears the queue, but after either one capture stays blocked until the enable has been seen at 0 and then at 1 again.

Top module: `branch_trace_queue`

## Requirements
- R1: An event (ev_valid=1) is stored only when trace_en is 1 and capture is armed; with trace_en at 0 it leaves the queue unchanged.
- R2: With ev_kind=0 (branch instruction) the stored source is ev_branch_pc and the stored destination is ev_target.
- R3: With ev_kind=1 (interrupt or exception) the stored source is ev_return_pc and the stored destination is ev_target.
- R4: The queue holds up to 4 pairs, and reads always return the oldest pair held.
- R5: A read strobe loads rd_data and rd_valid on the clock edge where it is sampled. rd_src_stb returns the oldest source and does not move the read pointer. rd_dst_stb returns the oldest destination and then removes that pair. If both strobes are high, rd_dst_stb wins. With no strobe, rd_data and rd_valid hold their values.
- R6: An event accepted while 4 pairs are held discards the oldest pair, so the newest 4 are kept.
- R7: A read of an empty or invalidated queue returns rd_data=0 with rd_valid=0, and the pointer does not move.
- R8: A cycle in which trace_en is 1, after being 0 in the previous cycle, invalidates every stored pair. An event in that same cycle is stored after the invalidation.
- R9: Power-on reset (rst_n low) empties the queue and clears rd_data and rd_valid. Afterwards, capture needs no enable toggle.
- R10: man_rst or dbg_srst empties the queue and clears rd_data and rd_valid. Capture then stays blocked until trace_en has been 0 for a cycle and is 1 again.
- R11: If an event is stored in the same cycle as a destination read of a non-empty queue, the pop happens first, and no event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous assert, active low |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| dbg_srst | input | 1 | Debug-unit software reset, synchronous, active high |
| trace_en | input | 1 | Trace enable control bit |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 1 | 0 = branch instruction, 1 = interrupt or exception |
| ev_branch_pc | input | 32 | Address of the branch instruction |
| ev_return_pc | input | 32 | Return address of an interrupt or exception |
| ev_target | input | 32 | Branch target or handler start address |
| rd_src_stb | input | 1 | Read oldest source address |
| rd_dst_stb | input | 1 | Read oldest destination address and retire the pair |
| rd_data | output | 32 | Read data register |
| rd_valid | output | 1 | Read data came from a valid entry |

## Verification
Most internal faults show up on the first destination read after the fault. A wrong occupancy count shows as a stale pair coming back, a missing pair, or an rd_valid of 1 on an empty queue. A bad shift shows as pairs out of order, or as a source and destination that do not belong together. The bench therefore drains the queue completely after every fill depth from zero to beyond full, and it reads the empty queue at the end. Any such error then appears within at most five read pairs. Faults in arming or invalidation are caught by reading right after the toggle or reset, in the next cycle.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic {
    EV_BRANCH = 1'b0,
    EV_EXCEPT = 1'b1
  } bt_kind_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_SRC  = 2'd1,
    RD_DST  = 2'd2
  } bt_rdop_e;

endpackage

// File: rtl/bt_event_select.sv
module bt_event_select
  import bt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          kind,
  input  logic [AW-1:0] branch_pc,
  input  logic [AW-1:0] return_pc,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pair_src,
  output logic [AW-1:0] pair_dst
);

  bt_kind_e kind_e;

  always_comb begin
    kind_e   = bt_kind_e'(kind);
    pair_dst = target;
    unique case (kind_e)
      EV_BRANCH: pair_src = branch_pc;
      EV_EXCEPT: pair_src = return_pc;
      default:   pair_src = branch_pc;
    endcase
  end

endmodule

// File: rtl/bt_arm_ctrl.sv
module bt_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic trace_en,
  output logic flush,
  output logic capture_ok
);

  logic en_q, en_d;
  logic need_low_q, need_low_d;

  // next state
  always_comb begin
    en_d       = trace_en;
    need_low_d = soft_rst | (need_low_q & trace_en);
    flush      = soft_rst | (trace_en & ~en_q);
    capture_ok = trace_en & ~need_low_q & ~soft_rst;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      need_low_q <= 1'b0;
    end else begin
      en_q       <= en_d;
      need_low_q <= need_low_d;
    end
  end

  // R10
  soft_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !capture_ok);

  // R1
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_en |-> !capture_ok);

endmodule

// File: rtl/bt_queue_store.sv
module bt_queue_store #(
  parameter int AW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [AW-1:0] push_src,
  input  logic [AW-1:0] push_dst,
  input  logic          pop_req,
  output logic [AW-1:0] head_src,
  output logic [AW-1:0] head_dst,
  output logic          not_empty
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] src_q [DEPTH];
  logic [AW-1:0] dst_q [DEPTH];
  logic [AW-1:0] src_d [DEPTH];
  logic [AW-1:0] dst_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop_eff;

  assign pop_eff   = pop_req & (cnt_q != '0) & ~flush;
  assign not_empty = (cnt_q != '0);
  assign head_src  = src_q[0];
  assign head_dst  = dst_q[0];

  // next state: invalidate, then pop, then append
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      src_d[i] = src_q[i];
      dst_d[i] = dst_q[i];
    end
    cnt_d = flush ? '0 : cnt_q;
    if (pop_eff) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        src_d[i] = src_d[i+1];
        dst_d[i] = dst_d[i+1];
      end
      src_d[DEPTH-1] = '0;
      dst_d[DEPTH-1] = '0;
      cnt_d = cnt_d - 1'b1;
    end
    if (push) begin
      if (cnt_d == FULL) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          src_d[i] = src_d[i+1];
          dst_d[i] = dst_d[i+1];
        end
        src_d[DEPTH-1] = push_src;
        dst_d[DEPTH-1] = push_dst;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (CW'(i) == cnt_d) begin
            src_d[i] = push_src;
            dst_d[i] = push_dst;
          end
        end
        cnt_d = cnt_d + 1'b1;
      end
    end
  end

  // registers with write enable
  logic upd;
  assign upd = flush | push | pop_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
      end
    end else if (upd) begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) begin
        src_q[i] <= src_d[i];
        dst_q[i] <= dst_d[i];
      end
    end
  end

  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_q <= CW'(1));

  // R11
  pop_push_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop_req && cnt_q != '0 && !flush) |=> cnt_q == $past(cnt_q));

  generate
    if (DEPTH > 1) begin : g_ovf
      // R6
      drop_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush && !pop_req && cnt_q == FULL)
          |=> (cnt_q == FULL) && (src_q[0] == $past(src_q[1])));
    end
  endgenerate

endmodule

// File: rtl/bt_read_port.sv
module bt_read_port
  import bt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          rd_src_stb,
  input  logic          rd_dst_stb,
  input  logic          not_empty,
  input  logic [AW-1:0] head_src,
  input  logic [AW-1:0] head_dst,
  output logic          pop_req,
  output logic [AW-1:0] rd_data,
  output logic          rd_valid
);

  bt_rdop_e      op;
  logic [AW-1:0] data_d;
  logic          valid_d;
  logic          load;

  // next state
  always_comb begin
    if (rd_dst_stb)      op = RD_DST;
    else if (rd_src_stb) op = RD_SRC;
    else                 op = RD_NONE;
    pop_req = (op == RD_DST);
    load    = soft_rst | (op != RD_NONE);
    data_d  = '0;
    valid_d = 1'b0;
    if (!soft_rst && not_empty) begin
      valid_d = 1'b1;
      data_d  = (op == RD_DST) ? head_dst : head_src;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else if (load) begin
      rd_data  <= data_d;
      rd_valid <= valid_d;
    end
  end

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_src_stb || rd_dst_stb) && !not_empty) |=> (rd_data == '0) && !rd_valid);

  // R5
  src_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src_stb && !rd_dst_stb && not_empty && !soft_rst)
      |=> rd_valid && (rd_data == $past(head_src)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_src_stb && !rd_dst_stb && !soft_rst) |=> $stable(rd_data) && $stable(rd_valid));

endmodule

// File: rtl/branch_trace_queue.sv
module branch_trace_queue #(
  parameter int AW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          man_rst,
  input  logic          dbg_srst,
  input  logic          trace_en,
  input  logic          ev_valid,
  input  logic          ev_kind,
  input  logic [AW-1:0] ev_branch_pc,
  input  logic [AW-1:0] ev_return_pc,
  input  logic [AW-1:0] ev_target,
  input  logic          rd_src_stb,
  input  logic          rd_dst_stb,
  output logic [AW-1:0] rd_data,
  output logic          rd_valid
);

  logic          soft_rst;
  logic          flush;
  logic          capture_ok;
  logic          push;
  logic          pop_req;
  logic          not_empty;
  logic [AW-1:0] pair_src, pair_dst;
  logic [AW-1:0] head_src, head_dst;

  assign soft_rst = man_rst | dbg_srst;
  assign push     = ev_valid & capture_ok;

  bt_event_select #(.AW(AW)) u_sel (
    .kind      (ev_kind),
    .branch_pc (ev_branch_pc),
    .return_pc (ev_return_pc),
    .target    (ev_target),
    .pair_src  (pair_src),
    .pair_dst  (pair_dst)
  );

  bt_arm_ctrl u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .trace_en   (trace_en),
    .flush      (flush),
    .capture_ok (capture_ok)
  );

  bt_queue_store #(.AW(AW), .DEPTH(DEPTH)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push),
    .push_src  (pair_src),
    .push_dst  (pair_dst),
    .pop_req   (pop_req),
    .head_src  (head_src),
    .head_dst  (head_dst),
    .not_empty (not_empty)
  );

  bt_read_port #(.AW(AW)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .rd_src_stb (rd_src_stb),
    .rd_dst_stb (rd_dst_stb),
    .not_empty  (not_empty),
    .head_src   (head_src),
    .head_dst   (head_dst),
    .pop_req    (pop_req),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

endmodule

// File: tb/sim_branch_trace_queue.sv
`timescale 1ns/1ps
module sim_branch_trace_queue;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        man_rst = 1'b0, dbg_srst = 1'b0, trace_en = 1'b0;
  logic        ev_valid = 1'b0, ev_kind = 1'b0;
  logic [31:0] ev_branch_pc = '0, ev_return_pc = '0, ev_target = '0;
  logic        rd_src_stb = 1'b0, rd_dst_stb = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model
  logic [31:0] m_src [4];
  logic [31:0] m_dst [4];
  int          m_cnt = 0;
  bit          m_need_low = 1'b0;
  bit          m_en_prev  = 1'b0;
  logic [31:0] e_data = '0;
  bit          e_valid = 1'b0;

  always #10 clk = ~clk;

  branch_trace_queue u0 (
    .clk(clk), .rst_n(rst_n), .man_rst(man_rst), .dbg_srst(dbg_srst),
    .trace_en(trace_en), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_branch_pc(ev_branch_pc), .ev_return_pc(ev_return_pc), .ev_target(ev_target),
    .rd_src_stb(rd_src_stb), .rd_dst_stb(rd_dst_stb),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(string req);
    checks++;
    if (rd_data !== e_data || rd_valid !== e_valid) begin
      errors++;
      $display("FAIL %s: got data=%h valid=%b, expected data=%h valid=%b",
               req, rd_data, rd_valid, e_data, e_valid);
    end
  endtask

  task automatic m_shift();
    for (int i = 0; i < 3; i++) begin
      m_src[i] = m_src[i+1];
      m_dst[i] = m_dst[i+1];
    end
  endtask

  // one clock: drive at negedge, update model, sample at next negedge
  task automatic cyc(bit ev, bit kind, logic [31:0] b, logic [31:0] r, logic [31:0] t,
                     bit rs, bit rd, bit srst_m, bit srst_d, string req);
    bit flush;
    ev_valid = ev; ev_kind = kind; ev_branch_pc = b; ev_return_pc = r; ev_target = t;
    rd_src_stb = rs; rd_dst_stb = rd; man_rst = srst_m; dbg_srst = srst_d;
    if (srst_m || srst_d) begin
      m_cnt = 0; m_need_low = 1'b1; m_en_prev = trace_en;
      e_data = '0; e_valid = 1'b0;
    end else begin
      flush = trace_en && !m_en_prev;
      if (rs || rd) begin
        e_valid = (m_cnt != 0);
        e_data  = (m_cnt == 0) ? 32'h0 : (rd ? m_dst[0] : m_src[0]);
      end
      if (flush) m_cnt = 0;
      if (rd && m_cnt != 0) begin m_shift(); m_cnt--; end
      if (ev && trace_en && !m_need_low) begin
        if (m_cnt == 4) begin m_shift(); m_cnt = 3; end
        m_src[m_cnt] = kind ? r : b;
        m_dst[m_cnt] = t;
        m_cnt++;
      end
      if (!trace_en) m_need_low = 1'b0;
      m_en_prev = trace_en;
    end
    @(negedge clk);
    ev_valid = 1'b0; rd_src_stb = 1'b0; rd_dst_stb = 1'b0; man_rst = 1'b0; dbg_srst = 1'b0;
    if (rs || rd || srst_m || srst_d) check(req);
  endtask

  task automatic idle();
    cyc(0, 0, '0, '0, '0, 0, 0, 0, 0, "");
  endtask

  task automatic event_n(int n, int i, bit kind);
    logic [31:0] b, r, t;
    b = 32'h0800_0000 + 32'(n << 8) + 32'(i * 4);
    r = b + 32'h2;
    t = 32'h0C00_0000 + 32'(n * 64) + 32'(i * 8);
    cyc(1, kind, b, r, t, 0, 0, 0, 0, "");
  endtask

  task automatic read_pair(string req);
    cyc(0, 0, '0, '0, '0, 1, 0, 0, 0, req);
    cyc(0, 0, '0, '0, '0, 0, 1, 0, 0, req);
  endtask

  task automatic toggle_en();
    trace_en = 1'b0; idle();
    trace_en = 1'b1; idle();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: power-on reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9");
    read_pair("R7");

    // R1: events ignored while disabled
    for (int i = 0; i < 3; i++) event_n(9, i, i[0]);
    read_pair("R1");

    // R2 / R3 / R4 / R6: sweep fill depth 0..6 with kinds mixed
    for (int n = 0; n <= 6; n++) begin
      toggle_en();
      for (int i = 0; i < n; i++) event_n(n, i, bit'((i + n) % 2));
      for (int k = 0; k < 5; k++) read_pair(n > 4 ? "R6" : (n[0] ? "R3" : "R2"));
    end

    // R5: source read repeated does not move pointer
    toggle_en();
    event_n(20, 0, 0); event_n(20, 1, 1);
    cyc(0, 0, '0, '0, '0, 1, 0, 0, 0, "R5");
    cyc(0, 0, '0, '0, '0, 1, 0, 0, 0, "R5");
    read_pair("R5"); read_pair("R4"); read_pair("R7");

    // R11: capture together with destination read
    event_n(21, 0, 0); event_n(21, 1, 1);
    cyc(0, 0, '0, '0, '0, 1, 0, 0, 0, "R11");
    cyc(1, 1, 32'h1111_0000, 32'h2222_0000, 32'h3333_0000, 0, 1, 0, 0, "R11");
    read_pair("R11"); read_pair("R11"); read_pair("R11");
    for (int i = 0; i < 4; i++) event_n(22, i, 0);
    cyc(1, 0, 32'h4444_0000, 32'h0, 32'h5555_0000, 0, 1, 0, 0, "R11");
    for (int k = 0; k < 5; k++) read_pair("R11");

    // R8: toggle invalidates, event in rising cycle is kept
    event_n(23, 0, 0); event_n(23, 1, 1);
    trace_en = 1'b0; idle();
    read_pair("R8");
    trace_en = 1'b1; event_n(23, 2, 0);
    read_pair("R8"); read_pair("R8");

    // R10: manual reset blocks capture until re-arm
    event_n(24, 0, 0);
    cyc(0, 0, '0, '0, '0, 0, 0, 1, 0, "R10");
    event_n(24, 1, 0);
    read_pair("R10");
    toggle_en();
    event_n(24, 2, 1);
    read_pair("R10");

    // R10: debug software reset
    event_n(25, 0, 1);
    cyc(0, 0, '0, '0, '0, 0, 0, 0, 1, "R10");
    event_n(25, 1, 1);
    read_pair("R10");
    trace_en = 1'b0; idle();
    event_n(25, 2, 0);
    trace_en = 1'b1; event_n(25, 3, 0);
    read_pair("R10"); read_pair("R10");

    // R9: power-on reset mid-run, capture without toggle
    event_n(26, 0, 0);
    rst_n = 1'b0;
    m_cnt = 0; m_need_low = 1'b0; m_en_prev = 1'b0; e_data = '0; e_valid = 1'b0;
    @(negedge clk);
    check("R9");
    rst_n = 1'b1;
    event_n(26, 1, 1);
    read_pair("R9"); read_pair("R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule